// File: doc/BRIEF.md
# Edge boundary mask generator

This unit turns a pair of byte addresses into a partial-store lane mask. The first address marks where a run of data begins and the second marks where it ends. The mask covers one 8-byte block. Software that walks a buffer one block at a time uses it to enable only the lanes that lie inside the buffer, so the first and last blocks can be written without touching bytes outside the run.

A lane can be a byte, a halfword or a word, and lane numbering can be big-endian or little-endian. If both addresses fall in the same 8-byte block, the mask covers only the lanes between them. Otherwise the mask runs from the start lane to the end of the block. Most variants also produce condition flags, as if the second address had been subtracted from the first, for both the 32-bit and the 64-bit result. Variants with the quiet bit set leave the flags untouched.

Requests enter on a valid/ready handshake and results leave on a second one. There is one register stage between them. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, the result holds and `in_ready` is low. The downstream side can therefore stall the unit for any number of cycles without losing a result.

Top module: `edge_mask_unit`

## Requirements
- R1: After reset, `out_valid`, `mask_out`, `flags_lo`, `flags_hi` and `flags_we` are all zero, and `in_ready` is high.
- R2: A request accepted on one edge produces `out_valid` on the following cycle. `in_ready` is high whenever no result is pending or the pending result is being taken. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R3: Lane size is set by variant bits [3:2]: 0 gives bytes, 1 gives halfwords, 2 gives words, and 3 is treated as bytes. The start index is taken from bits [2:0] of `addr_a` and the end index from bits [2:0] of `addr_b`, each shifted right by log2 of the lane size. For byte lanes in big-endian order (variant bit 1 clear), the start mask is 0xFF>>a and the end mask is the low 8 bits of 0xFF<<(7-b).
- R4: Variant bit 1 set selects little-endian order. For byte lanes, the start mask is the low 8 bits of 0xFF<<a and the end mask is 0xFF>>(7-b).
- R5: Halfword lanes use address bits [2:1] and give a 4-bit mask. In big-endian order the start/end masks for index 0..3 are F/8, 7/C, 3/E and 1/F. In little-endian order they are F/1, E/3, C/7 and 8/F.
- R6: Word lanes use address bit 2 and give a 2-bit mask. In big-endian order the start/end masks are 3/2 and 1/3. In little-endian order they are 3/1 and 2/3.
- R7: If the two addresses match in every bit above bit 2, the output mask is start AND end. Otherwise it is the start mask alone. Bits 63:8 of `mask_out` are always zero.
- R8: With `narrow_mode` high, only the low 32 bits of each address take part in the block comparison.
- R9: With variant bit 0 clear, `flags_hi` holds {N,Z,V,C} (bit 3 down to bit 0) of the full 64-bit `addr_a - addr_b`, and `flags_lo` holds the same four flags for the low 32 bits. The full addresses are used even in narrow mode. C is the unsigned borrow, and `flags_we` is high.
- R10: With variant bit 0 set, `flags_we` is low and `flags_lo`/`flags_hi` keep the values they had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| addr_a | input | 64 | Start address |
| addr_b | input | 64 | End address |
| variant | input | 4 | [0] quiet (no flag update), [1] little-endian, [3:2] lane size |
| narrow_mode | input | 1 | Use 32-bit addresses for the block comparison |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| mask_out | output | 64 | Lane mask, zero-extended |
| flags_lo | output | 4 | {N,Z,V,C} of the 32-bit difference |
| flags_hi | output | 4 | {N,Z,V,C} of the 64-bit difference |
| flags_we | output | 1 | Flags were updated by this result |

## Verification
The only state in the unit is the result register and the held flags. A wrong value there shows up at the ports on the same cycle `out_valid` rises, one cycle after acceptance. A held-flag fault can stay hidden until the next quiet variant. The bench therefore follows every quiet request with a check that both flag outputs still hold the values of the last flag-updating request. It also stalls `out_ready` for several cycles so that a register that reloads during a stall is seen within one cycle.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  localparam int BLOCK_BYTES = 8;
  localparam int OFS_W       = 3;
  localparam int N_SIZES     = 3;

  typedef enum logic [1:0] {
    ELEM_BYTE = 2'd0,
    ELEM_HALF = 2'd1,
    ELEM_WORD = 2'd2,
    ELEM_RSV  = 2'd3
  } elem_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/edge_lane_mask.sv
module edge_lane_mask
  import edge_mask_pkg::*;
#(
  parameter int LOG_ESZ = 0
) (
  input  logic [OFS_W-1:0]       ofs_l,
  input  logic [OFS_W-1:0]       ofs_r,
  input  logic                   little,
  output logic [BLOCK_BYTES-1:0] left_m,
  output logic [BLOCK_BYTES-1:0] right_m
);
  localparam int LANES = BLOCK_BYTES >> LOG_ESZ;
  localparam int IDX_W = OFS_W - LOG_ESZ;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] idx_l, idx_r, span_r;
  logic [LANES-1:0] ones, l_m, r_m;

  assign idx_l  = ofs_l[OFS_W-1:LOG_ESZ];
  assign idx_r  = ofs_r[OFS_W-1:LOG_ESZ];
  assign span_r = LAST - idx_r;
  assign ones   = '1;

  always_comb begin
    if (little) begin
      l_m = ones << idx_l;
      r_m = ones >> span_r;
    end else begin
      l_m = ones >> idx_l;
      r_m = ones << span_r;
    end
  end

  assign left_m  = BLOCK_BYTES'(l_m);
  assign right_m = BLOCK_BYTES'(r_m);
endmodule

// File: rtl/edge_flag_calc.sv
module edge_flag_calc
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  output nzvc_t             f_wide,
  output nzvc_t             f_narrow
);
  logic [ADDR_W:0]   d_wide;
  logic [NARROW_W:0] d_narrow;

  assign d_wide   = {1'b0, a} - {1'b0, b};
  assign d_narrow = {1'b0, a[NARROW_W-1:0]} - {1'b0, b[NARROW_W-1:0]};

  assign f_wide.n = d_wide[ADDR_W-1];
  assign f_wide.z = (d_wide[ADDR_W-1:0] == '0);
  assign f_wide.v = (a[ADDR_W-1] ^ b[ADDR_W-1]) & (a[ADDR_W-1] ^ d_wide[ADDR_W-1]);
  assign f_wide.c = d_wide[ADDR_W];

  assign f_narrow.n = d_narrow[NARROW_W-1];
  assign f_narrow.z = (d_narrow[NARROW_W-1:0] == '0);
  assign f_narrow.v = (a[NARROW_W-1] ^ b[NARROW_W-1]) & (a[NARROW_W-1] ^ d_narrow[NARROW_W-1]);
  assign f_narrow.c = d_narrow[NARROW_W];
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int MASK_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [3:0]        variant,
  input  logic              narrow_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MASK_W-1:0] mask_out,
  output logic [3:0]        flags_lo,
  output logic [3:0]        flags_hi,
  output logic              flags_we
);
  localparam int BLK_W = ADDR_W - OFS_W;

  logic [BLOCK_BYTES-1:0] lm [N_SIZES];
  logic [BLOCK_BYTES-1:0] rm [N_SIZES];

  genvar g;
  generate
    for (g = 0; g < N_SIZES; g++) begin : g_size
      edge_lane_mask #(.LOG_ESZ(g)) u_lane (
        .ofs_l  (addr_a[OFS_W-1:0]),
        .ofs_r  (addr_b[OFS_W-1:0]),
        .little (variant[1]),
        .left_m (lm[g]),
        .right_m(rm[g])
      );
    end
  endgenerate

  elem_e                  esz;
  logic [BLOCK_BYTES-1:0] sel_l, sel_r, mask_nxt;
  logic [ADDR_W-1:0]      eff_a, eff_b;
  logic                   same_blk, quiet, take;
  nzvc_t                  fw, fn;

  assign esz = elem_e'(variant[3:2]);

  always_comb begin
    case (esz)
      ELEM_HALF: begin sel_l = lm[1]; sel_r = rm[1]; end
      ELEM_WORD: begin sel_l = lm[2]; sel_r = rm[2]; end
      default:   begin sel_l = lm[0]; sel_r = rm[0]; end
    endcase
  end

  assign eff_a    = narrow_mode ? ADDR_W'(addr_a[NARROW_W-1:0]) : addr_a;
  assign eff_b    = narrow_mode ? ADDR_W'(addr_b[NARROW_W-1:0]) : addr_b;
  assign same_blk = (eff_a[ADDR_W-1 -: BLK_W] == eff_b[ADDR_W-1 -: BLK_W]);
  assign mask_nxt = same_blk ? (sel_l & sel_r) : sel_l;
  assign quiet    = variant[0];

  edge_flag_calc #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_flags (
    .a       (addr_a),
    .b       (addr_b),
    .f_wide  (fw),
    .f_narrow(fn)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mask_out  <= '0;
      flags_lo  <= '0;
      flags_hi  <= '0;
      flags_we  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      mask_out  <= MASK_W'(mask_nxt);
      flags_we  <= !quiet;
      if (!quiet) begin
        flags_lo <= fn;
        flags_hi <= fw;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module edge_mask_unit_chk #(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [3:0]        variant,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MASK_W-1:0] mask_out,
  input logic [3:0]        flags_lo,
  input logic [3:0]        flags_hi,
  input logic              flags_we
);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(mask_out) &&
                                   $stable(flags_hi) && $stable(flags_lo)));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mask_out[MASK_W-1:8] == '0));

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !variant[0]) |=>
      (flags_we && (flags_hi[2] == ($past(addr_a) == $past(addr_b)))));

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && variant[0]) |=>
      (!flags_we && $stable(flags_hi) && $stable(flags_lo)));
endmodule

bind edge_mask_unit edge_mask_unit_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .addr_a(addr_a), .addr_b(addr_b), .variant(variant),
  .out_valid(out_valid), .out_ready(out_ready), .mask_out(mask_out),
  .flags_lo(flags_lo), .flags_hi(flags_hi), .flags_we(flags_we)
);

// File: tb/edge_mask_unit_test.sv
`timescale 1ns/1ps
module edge_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] addr_a = '0, addr_b = '0;
  logic [3:0]  variant = '0;
  logic        narrow_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] mask_out;
  logic [3:0]  flags_lo, flags_hi;
  logic        flags_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  typedef struct {
    logic [63:0] m;
    logic [3:0]  lo;
    logic [3:0]  hi;
    logic        we;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [3:0] last_lo = '0, last_hi = '0;

  edge_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .addr_a(addr_a), .addr_b(addr_b), .variant(variant), .narrow_mode(narrow_mode),
    .out_valid(out_valid), .out_ready(out_ready), .mask_out(mask_out),
    .flags_lo(flags_lo), .flags_hi(flags_hi), .flags_we(flags_we)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] ref_flags(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [64:0] sd, ud;
    logic [63:0] am, bm, d;
    logic n, z, v, c;
    am = (w == 32) ? {32'b0, a[31:0]} : a;
    bm = (w == 32) ? {32'b0, b[31:0]} : b;
    ud = {1'b0, am} - {1'b0, bm};
    d  = ud[63:0];
    if (w == 32) begin
      n = d[31];
      z = (d[31:0] == 0);
      c = ud[64];
      sd = {{33{a[31]}}, a[31:0]} - {{33{b[31]}}, b[31:0]};
      v = (sd[32] != sd[31]);
    end else begin
      n = d[63];
      z = (d == 0);
      c = ud[64];
      sd = {a[63], a} - {b[63], b};
      v = (sd[64] != sd[63]);
    end
    return {n, z, v, c};
  endfunction

  // Element e (0 = lowest address) sits at mask bit E-1-e (big-endian) or e (little-endian)
  function automatic logic [63:0] ref_mask(input logic [63:0] a, input logic [63:0] b,
                                           input logic [3:0] v, input logic nar);
    int lg, ne, i, j, bitp;
    logic [7:0] lm, rm;
    logic [63:0] ta, tb;
    lg = (v[3:2] == 2'd3) ? 0 : int'(v[3:2]);
    ne = 8 >> lg;
    i  = int'(a[2:0]) >> lg;
    j  = int'(b[2:0]) >> lg;
    lm = '0; rm = '0;
    for (int e = 0; e < ne; e++) begin
      bitp = v[1] ? e : ne - 1 - e;
      if (e >= i) lm[bitp] = 1'b1;
      if (e <= j) rm[bitp] = 1'b1;
    end
    ta = nar ? {32'b0, a[31:0]} : a;
    tb = nar ? {32'b0, b[31:0]} : b;
    return ((ta >> 3) == (tb >> 3)) ? {56'b0, lm & rm} : {56'b0, lm};
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [3:0] v,
                      input logic nar, input string tag);
    exp_t x;
    bit acc;
    x.m = ref_mask(a, b, v, nar);
    if (!v[0]) begin
      last_lo = ref_flags(a, b, 32);
      last_hi = ref_flags(a, b, 64);
    end
    x.lo = last_lo; x.hi = last_hi; x.we = !v[0]; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    addr_a = a; addr_b = b; variant = v; narrow_mode = nar; in_valid = 1'b1;
    forever begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready pattern, changed at negedge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_mode ? ((cyc % 6) >= 4) : 1'b1;
  end

  // Monitor / scoreboard
  logic        held_pend = 1'b0;
  logic [63:0] held_m;
  logic [3:0]  held_lo, held_hi;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held_pend) begin
        checks++;
        if (!(out_valid && mask_out == held_m && flags_lo == held_lo && flags_hi == held_hi)) begin
          failures++;
          $display("FAIL R2 stall hold: got v=%0b m=%h lo=%h hi=%h exp v=1 m=%h lo=%h hi=%h",
                   out_valid, mask_out, flags_lo, flags_hi, held_m, held_lo, held_hi);
        end
      end
      held_pend = out_valid && !out_ready;
      held_m = mask_out; held_lo = flags_lo; held_hi = flags_hi;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 unexpected result m=%h expected none", mask_out);
        end else begin
          exp_t x;
          x = sb.pop_front();
          checks++;
          if (mask_out !== x.m || flags_lo !== x.lo || flags_hi !== x.hi || flags_we !== x.we) begin
            failures++;
            $display("FAIL %s: got m=%h lo=%h hi=%h we=%0b exp m=%h lo=%h hi=%h we=%0b",
                     x.tag, mask_out, flags_lo, flags_hi, flags_we, x.m, x.lo, x.hi, x.we);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || mask_out !== '0 || flags_lo !== '0 || flags_hi !== '0 ||
        flags_we !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: got v=%0b m=%h lo=%h hi=%h we=%0b rdy=%0b exp all zero, ready 1",
               out_valid, mask_out, flags_lo, flags_hi, flags_we, in_ready);
    end

    // R3 byte big-endian, same block
    send(64'h1000, 64'h1007, 4'h0, 1'b0, "R3 a0 b7");
    send(64'h1003, 64'h1005, 4'h1, 1'b0, "R3 a3 b5");
    send(64'h1005, 64'h1002, 4'h1, 1'b0, "R3 a5 b2 empty");
    // R4 byte little-endian
    send(64'h2002, 64'h2006, 4'h2, 1'b0, "R4 a2 b6");
    send(64'h2007, 64'h2007, 4'h3, 1'b0, "R4 a7 b7");
    // R5 halfword lanes
    for (int k = 0; k < 4; k++) begin
      send(64'h3000 + 64'(2*k), 64'h3006 - 64'(2*k), 4'h4, 1'b0, "R5 be");
      send(64'h3000 + 64'(2*k), 64'h3000 + 64'(2*k), 4'h7, 1'b0, "R5 le");
    end
    // R6 word lanes and reserved size code
    send(64'h4000, 64'h4000, 4'h8, 1'b0, "R6 be i0");
    send(64'h4004, 64'h4004, 4'h9, 1'b0, "R6 be i1");
    send(64'h4004, 64'h4000, 4'hA, 1'b0, "R6 le");
    send(64'h4001, 64'h4006, 4'hD, 1'b0, "R6 size code 3 as byte");
    // R7 different blocks -> left only
    send(64'h5003, 64'h5013, 4'h0, 1'b0, "R7 diff block be");
    send(64'h5005, 64'h9000_0000_0000_5001, 4'h6, 1'b0, "R7 diff block le half");
    // R8 narrow mode
    send(64'hAAAA_0000_0000_6002, 64'h5555_0000_0000_6004, 4'h1, 1'b1, "R8 narrow same");
    send(64'hAAAA_0000_0000_6002, 64'h5555_0000_0000_6004, 4'h1, 1'b0, "R8 wide differ");
    // R9 flags
    send(64'h1234, 64'h1234, 4'h0, 1'b0, "R9 zero");
    send(64'h10, 64'h20, 4'h0, 1'b0, "R9 borrow");
    send(64'h8000_0000_0000_0000, 64'h1, 4'h4, 1'b0, "R9 wide overflow");
    send(64'h0000_0001_8000_0000, 64'h1, 4'h8, 1'b1, "R9 narrow overflow full addr");
    // R10 quiet keeps flags
    send(64'h7, 64'h9999, 4'h1, 1'b0, "R10 quiet keeps flags");
    send(64'hFFFF, 64'h0, 4'hB, 1'b0, "R10 quiet le word");
    // R2 back-pressure run
    stall_mode = 1'b1;
    for (int k = 0; k < 10; k++)
      send(64'(k * 5), 64'(k * 3 + 1), 4'(k % 12), k[0], "R2 stalled stream");
    stall_mode = 1'b0;
    repeat (12) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R2 drain: got %0d pending exp 0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule